// File: doc/BRIEF.md
# Received Audio Sample Formatter

This block sits behind a digital-audio biphase decoder and turns the decoded subframes into bus-ready data words. Each subframe arrives as a one-cycle strobe with a 24-bit audio sample, a validity bit, a parity bit and a start-of-block marker. The block checks parity and drops samples according to the configured filters. It cuts each accepted sample to the chosen width and orders the bytes as configured. In 16-bit pack mode it joins two samples into one word. The result goes into a single holding register that a bus master or DMA engine reads, with ready, overrun and parity-error flags beside it.

Configuration comes from an 8-bit mode register, written through a one-cycle write strobe. A software-reset strobe returns the mode, the holding register, the pack state and all status flags to their reset values. All logic runs on one clock with a synchronous, active-high reset.

Top module: `rx_sample_formatter`

## Requirements
- R1: While mode bit 0 (receive enable) is 0, subframes change neither the holding register, nor the ready flag, nor the parity-error flag. Any half-built pack word is discarded.
- R2: When mode bit 3 is 1, a subframe whose validity bit is 1 is dropped. When mode bit 3 is 0, such a subframe is loaded like any other.
- R3: When mode bit 4 is 1, a subframe whose start-of-block marker is 1 is dropped. When mode bit 4 is 0, it is loaded.
- R4: Mode bits 7:6 select the width: code 0 is 24 bits, code 1 is 20 bits, codes 2 and 3 are 16 bits. The most significant bits of the 24-bit sample are kept, right-aligned in a 32-bit word with the upper bits zero.
- R5: When mode bit 2 is 0, the word is stored as aligned. When mode bit 2 is 1, the four bytes of the aligned word are reversed. In pack mode, the two bytes inside each 16-bit half are swapped instead.
- R6: When mode bit 5 is 0, each enabled subframe must have an even number of ones over its sample, validity and parity bits. Otherwise the sticky parity-error flag is set, and the sample is still processed. When mode bit 5 is 1, no check is made.
- R7: When mode bit 1 is 1 and the width is 16 bits, the first accepted sample is held and nothing is loaded. The second sample is loaded together with it: first sample in bits 15:0, second sample in bits 31:16. At other widths, mode bit 1 has no effect.
- R8: A word loads into the holding register on the clock edge that ends the strobe cycle, and the ready flag is set. A read strobe clears ready on the next edge, unless a new word loads on that same edge.
- R9: If a word loads while ready is set and no read happens on the same edge, the sticky overrun flag is set and the newer word replaces the older one.
- R10: A software-reset strobe clears the mode register, the holding register, the pack state, ready, overrun and parity-error on the next edge. It takes priority over a mode write on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_rst | input | 1 | Software-reset strobe |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write value |
| sf_vld | input | 1 | Subframe strobe, one cycle per subframe |
| sf_data | input | 24 | Decoded audio sample |
| sf_validity | input | 1 | Validity bit of the subframe |
| sf_parity | input | 1 | Parity bit of the subframe |
| sf_blk_start | input | 1 | Start-of-block marker |
| hold_rd | input | 1 | Holding register read strobe |
| hold_data | output | 32 | Holding register contents |
| stat_ready | output | 1 | Holding register holds unread data |
| stat_overrun | output | 1 | Sticky overrun flag |
| stat_parity_err | output | 1 | Sticky parity-error flag |

## Verification
The assertions assume that the decoder presents each subframe as a single-cycle strobe. They also assume that sf_validity and sf_blk_start are meaningful only while that strobe is high. The filter properties are written against the internal load pulse, so they hold whatever the pack state. The stimulus drives every input on the falling clock edge and holds each strobe for exactly one cycle. It issues mode writes only between subframes and clears ready by reading before each new pattern, unless the overrun or same-edge read cases are under test.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;

    localparam int SMP_W  = 24;
    localparam int WRD_W  = 32;
    localparam int BYTE_W = 8;
    localparam int NBYTES = WRD_W / BYTE_W;
    localparam int HALF_W = WRD_W / 2;

    typedef enum logic [1:0] {
        WCODE_24 = 2'd0,
        WCODE_20 = 2'd1,
        WCODE_16 = 2'd2,
        WCODE_RS = 2'd3
    } width_code_e;

    typedef struct packed {
        logic [1:0] width_code;
        logic       par_off;
        logic       drop_blk;
        logic       drop_inv;
        logic       big_end;
        logic       pack;
        logic       rx_en;
    } mode_t;

    typedef struct packed {
        logic [SMP_W-1:0] data;
        logic             validity;
        logic             parity;
        logic             blk_start;
    } subframe_t;

    function automatic logic is_narrow16(logic [1:0] code);
        return code[1];
    endfunction

    function automatic logic [WRD_W-1:0] right_align(logic [SMP_W-1:0] s,
                                                     logic [1:0] code);
        logic [WRD_W-1:0] r;
        case (code)
            WCODE_24: r = {{(WRD_W-SMP_W){1'b0}}, s};
            WCODE_20: r = {{(WRD_W-20){1'b0}}, s[SMP_W-1 -: 20]};
            default:  r = {{(WRD_W-16){1'b0}}, s[SMP_W-1 -: 16]};
        endcase
        return r;
    endfunction

    function automatic logic [WRD_W-1:0] swap_word(logic [WRD_W-1:0] w);
        logic [WRD_W-1:0] r;
        for (int b = 0; b < NBYTES; b++)
            r[b*BYTE_W +: BYTE_W] = w[(NBYTES-1-b)*BYTE_W +: BYTE_W];
        return r;
    endfunction

    function automatic logic [WRD_W-1:0] swap_halves(logic [WRD_W-1:0] w);
        logic [WRD_W-1:0] r;
        for (int h = 0; h < 2; h++) begin
            r[h*HALF_W          +: BYTE_W] = w[h*HALF_W+BYTE_W +: BYTE_W];
            r[h*HALF_W+BYTE_W   +: BYTE_W] = w[h*HALF_W        +: BYTE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/sfmt_filter.sv
module sfmt_filter
    import sfmt_pkg::*;
(
    input  logic      sf_vld,
    input  subframe_t sf,
    input  logic      rx_en,
    input  logic      drop_inv,
    input  logic      drop_blk,
    input  logic      par_off,
    output logic      accept,
    output logic      par_bad
);
    logic live;
    logic odd_ones;
    logic kill_inv;
    logic kill_blk;

    always_comb begin
        live     = sf_vld && rx_en;
        odd_ones = ^{sf.data, sf.validity, sf.parity};
        kill_inv = drop_inv && sf.validity;
        kill_blk = drop_blk && sf.blk_start;
        accept   = live && !kill_inv && !kill_blk;
        par_bad  = live && !par_off && odd_ones;
    end

endmodule

// File: rtl/sfmt_word_builder.sv
module sfmt_word_builder
    import sfmt_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  logic             rx_en,
    input  logic             accept,
    input  logic [SMP_W-1:0] sample,
    input  logic [1:0]       width_code,
    input  logic             big_end,
    input  logic             pack,
    output logic             load_word,
    output logic [WRD_W-1:0] word
);
    logic              pack_active;
    logic              half_vld_q;
    logic [HALF_W-1:0] half_lo_q;
    logic [WRD_W-1:0]  aligned;
    logic [WRD_W-1:0]  joined;

    always_comb begin
        pack_active = pack && is_narrow16(width_code);
        aligned     = right_align(sample, width_code);
        joined      = {aligned[HALF_W-1:0], half_lo_q};
        if (pack_active) begin
            load_word = accept && half_vld_q;
            word      = big_end ? swap_halves(joined) : joined;
        end else begin
            load_word = accept;
            word      = big_end ? swap_word(aligned) : aligned;
        end
    end

    always_ff @(posedge clk) begin
        if (clr || !rx_en || !pack_active) begin
            half_vld_q <= 1'b0;
            half_lo_q  <= '0;
        end else if (accept) begin
            half_vld_q <= !half_vld_q;
            if (!half_vld_q)
                half_lo_q <= aligned[HALF_W-1:0];
        end
    end

endmodule

// File: rtl/sfmt_hold.sv
module sfmt_hold
    import sfmt_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic [WRD_W-1:0] word,
    input  logic             rd,
    input  logic             par_bad,
    output logic [WRD_W-1:0] data,
    output logic             ready,
    output logic             overrun,
    output logic             par_err
);
    always_ff @(posedge clk) begin
        if (clr) begin
            data    <= '0;
            ready   <= 1'b0;
            overrun <= 1'b0;
            par_err <= 1'b0;
        end else begin
            if (load) begin
                data  <= word;
                ready <= 1'b1;
                if (ready && !rd)
                    overrun <= 1'b1;
            end else if (rd) begin
                ready <= 1'b0;
            end
            if (par_bad)
                par_err <= 1'b1;
        end
    end

endmodule

// File: rtl/rx_sample_formatter.sv
module rx_sample_formatter
    import sfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_rst,
    input  logic             mode_wr,
    input  logic [7:0]       mode_wdata,
    input  logic             sf_vld,
    input  logic [SMP_W-1:0] sf_data,
    input  logic             sf_validity,
    input  logic             sf_parity,
    input  logic             sf_blk_start,
    input  logic             hold_rd,
    output logic [WRD_W-1:0] hold_data,
    output logic             stat_ready,
    output logic             stat_overrun,
    output logic             stat_parity_err
);
    logic             clr;
    mode_t            mode_s;
    logic [7:0]       mode_q;
    subframe_t        sf;
    logic             accept;
    logic             par_bad;
    logic             load_word;
    logic [WRD_W-1:0] word;

    assign clr    = rst || sw_rst;
    assign mode_s = mode_t'(mode_q);
    assign sf     = '{data: sf_data, validity: sf_validity,
                      parity: sf_parity, blk_start: sf_blk_start};

    always_ff @(posedge clk) begin
        if (clr)
            mode_q <= '0;
        else if (mode_wr)
            mode_q <= mode_wdata;
    end

    sfmt_filter u_filter (
        .sf_vld   (sf_vld),
        .sf       (sf),
        .rx_en    (mode_s.rx_en),
        .drop_inv (mode_s.drop_inv),
        .drop_blk (mode_s.drop_blk),
        .par_off  (mode_s.par_off),
        .accept   (accept),
        .par_bad  (par_bad)
    );

    sfmt_word_builder u_builder (
        .clk        (clk),
        .clr        (clr),
        .rx_en      (mode_s.rx_en),
        .accept     (accept),
        .sample     (sf.data),
        .width_code (mode_s.width_code),
        .big_end    (mode_s.big_end),
        .pack       (mode_s.pack),
        .load_word  (load_word),
        .word       (word)
    );

    sfmt_hold u_hold (
        .clk     (clk),
        .clr     (clr),
        .load    (load_word),
        .word    (word),
        .rd      (hold_rd),
        .par_bad (par_bad),
        .data    (hold_data),
        .ready   (stat_ready),
        .overrun (stat_overrun),
        .par_err (stat_parity_err)
    );

endmodule

// File: rtl/sfmt_checker.sv
module sfmt_checker (
    input logic        clk,
    input logic        rst,
    input logic        sw_rst,
    input logic        sf_vld,
    input logic        sf_validity,
    input logic        sf_blk_start,
    input logic        hold_rd,
    input logic [31:0] hold_data,
    input logic        stat_ready,
    input logic        stat_overrun,
    input logic        stat_parity_err,
    input logic [7:0]  mode_q,
    input logic        load_word
);
    // R1: disabled receiver leaves the holding register and parity flag alone
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!mode_q[0] && !sw_rst) |=> ($stable(hold_data) && $stable(stat_parity_err)));

    p_drop_invalid_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_q[0] && mode_q[3] && sf_vld && sf_validity) |-> !load_word);

    p_drop_blkstart_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_q[0] && mode_q[4] && sf_vld && sf_blk_start) |-> !load_word);

    p_parity_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (stat_parity_err && !sw_rst) |=> stat_parity_err);

    p_load_sets_ready_r8: assert property (@(posedge clk) disable iff (rst)
        (load_word && !sw_rst) |=> stat_ready);

    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (hold_rd && !load_word) |=> !stat_ready);

    p_overrun_set_r9: assert property (@(posedge clk) disable iff (rst)
        (load_word && stat_ready && !hold_rd && !sw_rst) |=> stat_overrun);

    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (stat_overrun && !sw_rst) |=> stat_overrun);

    p_swreset_r10: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> (mode_q == 8'h00 && !stat_ready && !stat_overrun
                     && !stat_parity_err && hold_data == 32'h0));

endmodule

bind rx_sample_formatter sfmt_checker u_sfmt_checker (
    .clk             (clk),
    .rst             (rst),
    .sw_rst          (sw_rst),
    .sf_vld          (sf_vld),
    .sf_validity     (sf_validity),
    .sf_blk_start    (sf_blk_start),
    .hold_rd         (hold_rd),
    .hold_data       (hold_data),
    .stat_ready      (stat_ready),
    .stat_overrun    (stat_overrun),
    .stat_parity_err (stat_parity_err),
    .mode_q          (mode_q),
    .load_word       (load_word)
);

// File: tb/test_rx_sample_formatter.sv
module test_rx_sample_formatter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_rst = 1'b0;
    logic        mode_wr = 1'b0;
    logic [7:0]  mode_wdata = '0;
    logic        sf_vld = 1'b0;
    logic [23:0] sf_data = '0;
    logic        sf_validity = 1'b0;
    logic        sf_parity = 1'b0;
    logic        sf_blk_start = 1'b0;
    logic        hold_rd = 1'b0;
    logic [31:0] hold_data;
    logic        stat_ready;
    logic        stat_overrun;
    logic        stat_parity_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rx_sample_formatter i_rx_sample_formatter (
        .clk             (clk),
        .rst             (rst),
        .sw_rst          (sw_rst),
        .mode_wr         (mode_wr),
        .mode_wdata      (mode_wdata),
        .sf_vld          (sf_vld),
        .sf_data         (sf_data),
        .sf_validity     (sf_validity),
        .sf_parity       (sf_parity),
        .sf_blk_start    (sf_blk_start),
        .hold_rd         (hold_rd),
        .hold_data       (hold_data),
        .stat_ready      (stat_ready),
        .stat_overrun    (stat_overrun),
        .stat_parity_err (stat_parity_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_mode(input bit en, input bit pk, input bit big,
                                           input bit dinv, input bit dblk,
                                           input bit poff, input logic [1:0] code);
        return {code, poff, dblk, dinv, big, pk, en};
    endfunction

    function automatic logic [31:0] exp_align(input logic [23:0] s, input logic [1:0] code);
        int w;
        w = (code == 2'd0) ? 24 : (code == 2'd1) ? 20 : 16;
        return 32'(s) >> (24 - w);
    endfunction

    function automatic logic [31:0] rev4(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic write_mode(input logic [7:0] m);
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic send(input logic [23:0] s, input bit v, input bit sb,
                        input bit bad_par, input bit rd);
        @(negedge clk);
        sf_vld = 1'b1; sf_data = s; sf_validity = v; sf_blk_start = sb;
        sf_parity = (^{s, v}) ^ bad_par;
        hold_rd = rd;
        @(negedge clk);
        sf_vld = 1'b0; sf_validity = 1'b0; sf_blk_start = 1'b0; hold_rd = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk);
        hold_rd = 1'b1;
        @(negedge clk);
        hold_rd = 1'b0;
    endtask

    task automatic soft_reset();
        @(negedge clk);
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %h expected %h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [23:0] a;
        logic [23:0] b;
        logic [31:0] e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R8, R10)
        chk(!stat_ready && !stat_overrun && !stat_parity_err && hold_data == 0,
            "R10 reset state", {stat_ready, stat_overrun, stat_parity_err}, 0);

        // R1: disabled receiver ignores subframes, including bad parity
        write_mode(mk_mode(0, 0, 0, 0, 0, 0, 2'd0));
        send(24'hABCDEF, 0, 0, 1, 0);
        chk(!stat_ready, "R1 no ready while disabled", 32'(stat_ready), 0);
        chk(hold_data == 0, "R1 data untouched while disabled", hold_data, 0);
        chk(!stat_parity_err, "R1 no parity check while disabled", 32'(stat_parity_err), 0);

        // R4/R5/R8 sweep over width codes, byte order, pack off
        for (int code = 0; code < 4; code++) begin
            for (int big = 0; big < 2; big++) begin
                write_mode(mk_mode(1, 0, big[0], 0, 0, 0, code[1:0]));
                for (int k = 0; k < 6; k++) begin
                    a = 24'h9A5C31 ^ 24'(k * 32'h1F3A7) ^ 24'(code * 32'h80301);
                    send(a, 0, 0, 0, 0);
                    e = exp_align(a, code[1:0]);
                    if (big != 0) e = rev4(e);
                    chk(hold_data == e, big != 0 ? "R5 big-endian word" : "R4 width alignment",
                        hold_data, e);
                    chk(stat_ready, "R8 ready after load", 32'(stat_ready), 1);
                    do_read();
                    chk(!stat_ready, "R8 read clears ready", 32'(stat_ready), 0);
                end
            end
        end

        // R7: packing for 16-bit codes, both byte orders
        for (int code = 2; code < 4; code++) begin
            for (int big = 0; big < 2; big++) begin
                write_mode(mk_mode(1, 1, big[0], 0, 0, 0, code[1:0]));
                for (int k = 0; k < 3; k++) begin
                    a = 24'h13579B + 24'(k * 32'h10203);
                    b = 24'hFEDCBA - 24'(k * 32'h30201);
                    send(a, 0, 0, 0, 0);
                    chk(!stat_ready, "R7 first half not loaded", 32'(stat_ready), 0);
                    send(b, 0, 0, 0, 0);
                    e = {b[23:8], a[23:8]};
                    if (big != 0) e = {e[23:16], e[31:24], e[7:0], e[15:8]};
                    chk(hold_data == e, "R7 packed word", hold_data, e);
                    chk(stat_ready, "R7 ready after second half", 32'(stat_ready), 1);
                    do_read();
                end
            end
        end
        // R7: pack bit has no effect at 24 bits
        write_mode(mk_mode(1, 1, 0, 0, 0, 0, 2'd0));
        send(24'h445566, 0, 0, 0, 0);
        chk(stat_ready && hold_data == 32'h00445566, "R7 pack ignored at 24 bits",
            hold_data, 32'h00445566);
        do_read();

        // R1: disabling drops a half-built pack word
        write_mode(mk_mode(1, 1, 0, 0, 0, 0, 2'd2));
        send(24'h111100, 0, 0, 0, 0);
        write_mode(mk_mode(0, 1, 0, 0, 0, 0, 2'd2));
        write_mode(mk_mode(1, 1, 0, 0, 0, 0, 2'd2));
        send(24'h222200, 0, 0, 0, 0);
        chk(!stat_ready, "R1 pack half discarded on disable", 32'(stat_ready), 0);
        send(24'h333300, 0, 0, 0, 0);
        chk(hold_data == 32'h33332222, "R1 pack restarts after disable", hold_data, 32'h33332222);
        do_read();

        // R2: validity filtering
        write_mode(mk_mode(1, 0, 0, 1, 0, 0, 2'd0));
        send(24'h0F0F0F, 1, 0, 0, 0);
        chk(!stat_ready, "R2 invalid sample dropped", 32'(stat_ready), 0);
        send(24'h0F0F0E, 0, 0, 0, 0);
        chk(stat_ready && hold_data == 32'h000F0F0E, "R2 valid sample kept", hold_data, 32'h000F0F0E);
        do_read();
        write_mode(mk_mode(1, 0, 0, 0, 0, 0, 2'd0));
        send(24'h0A0B0C, 1, 0, 0, 0);
        chk(stat_ready && hold_data == 32'h000A0B0C, "R2 invalid loaded when filter off",
            hold_data, 32'h000A0B0C);
        do_read();

        // R3: block-start filtering
        write_mode(mk_mode(1, 0, 0, 0, 1, 0, 2'd0));
        send(24'h777777, 0, 1, 0, 0);
        chk(!stat_ready, "R3 block start dropped", 32'(stat_ready), 0);
        write_mode(mk_mode(1, 0, 0, 0, 0, 0, 2'd0));
        send(24'h787878, 0, 1, 0, 0);
        chk(stat_ready && hold_data == 32'h00787878, "R3 block start kept when filter off",
            hold_data, 32'h00787878);
        do_read();

        // R6: parity checking
        write_mode(mk_mode(1, 0, 0, 0, 0, 1, 2'd0));
        send(24'h123456, 0, 0, 1, 0);
        chk(!stat_parity_err, "R6 no flag when check disabled", 32'(stat_parity_err), 0);
        do_read();
        write_mode(mk_mode(1, 0, 0, 0, 0, 0, 2'd0));
        send(24'h123457, 0, 0, 0, 0);
        chk(!stat_parity_err, "R6 good parity no flag", 32'(stat_parity_err), 0);
        do_read();
        send(24'h654321, 1, 0, 1, 0);
        chk(stat_parity_err, "R6 bad parity flagged", 32'(stat_parity_err), 1);
        chk(hold_data == 32'h00654321, "R6 bad-parity sample still loaded", hold_data, 32'h00654321);
        do_read();
        send(24'h000001, 0, 0, 0, 0);
        chk(stat_parity_err, "R6 flag sticky", 32'(stat_parity_err), 1);
        do_read();

        // R8: load and read on the same edge keeps ready, no overrun
        send(24'h0000AA, 0, 0, 0, 0);
        send(24'h0000BB, 0, 0, 0, 1);
        chk(stat_ready && !stat_overrun, "R8 same-edge read and load",
            {stat_ready, stat_overrun}, 32'h2);
        chk(hold_data == 32'h000000BB, "R8 same-edge load data", hold_data, 32'h000000BB);
        do_read();

        // R9: overrun
        send(24'h0000C1, 0, 0, 0, 0);
        send(24'h0000C2, 0, 0, 0, 0);
        chk(stat_overrun, "R9 overrun set", 32'(stat_overrun), 1);
        chk(hold_data == 32'h000000C2, "R9 newer word wins", hold_data, 32'h000000C2);
        do_read();
        chk(stat_overrun && !stat_ready, "R9 overrun sticky after read", 32'(stat_overrun), 1);

        // R10: software reset wins over a simultaneous mode write
        send(24'h0000D0, 0, 0, 0, 0);
        @(negedge clk);
        sw_rst = 1'b1; mode_wr = 1'b1; mode_wdata = mk_mode(1, 0, 0, 0, 0, 0, 2'd0);
        @(negedge clk);
        sw_rst = 1'b0; mode_wr = 1'b0;
        chk(!stat_ready && !stat_overrun && !stat_parity_err && hold_data == 0,
            "R10 status cleared", {stat_ready, stat_overrun, stat_parity_err}, 0);
        send(24'h0000E0, 0, 0, 0, 0);
        chk(!stat_ready, "R10 mode cleared so receiver off", 32'(stat_ready), 0);

        // R10: software reset clears pack state
        write_mode(mk_mode(1, 1, 0, 0, 0, 0, 2'd2));
        send(24'h555500, 0, 0, 0, 0);
        soft_reset();
        write_mode(mk_mode(1, 1, 0, 0, 0, 0, 2'd2));
        send(24'h666600, 0, 0, 0, 0);
        chk(!stat_ready, "R10 pack half cleared", 32'(stat_ready), 0);
        send(24'h888800, 0, 0, 0, 0);
        chk(hold_data == 32'h88886666, "R10 pack after reset", hold_data, 32'h88886666);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule